// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the read and write strobes for programmed-I/O transfers on a host with two IDE channels and two drives per channel. Each transfer is split into three timed phases: an address-setup phase with no strobe, an active phase with the strobe asserted, and a recovery phase with the strobe released. A one-cycle completion pulse follows the recovery phase. The length of each phase comes from timing bytes that software writes through a small register port.

Timing is held in encoded form. Each setup byte has a 2-bit non-linear code in its top bits. Each read/write timing byte has an active nibble and a recovery nibble, and a nibble value of zero means sixteen clocks. A 2-bit silicon revision input adds one clock to recovery on newer parts. The two primary-channel drives each have their own pair of bytes. The two secondary-channel drives share one pair. The block takes a copy of the selected drive's counts when a transfer starts, so writes to the registers during a transfer do not change it.

Top module: `ide_pio_strobe_timer`

## Requirements
- R1: After reset, every timing register reads 0x00. That value gives a setup of 4 clocks, an active phase of 16 clocks and a recovery phase of 16 clocks (17 when the revision is greater than 1).
- R2: Register addresses are 0 = drive-0 setup, 1 = drive-0 timing, 2 = drive-1 setup, 3 = drive-1 timing, 4 = secondary setup and 5 = secondary timing. Addresses 6 and 7 read 0x00 and ignore writes. A full write stores all 8 bits, and a read returns them.
- R3: A write to a setup register (addresses 0, 2 or 4) with `cfg_setup_only` high replaces only bits 7:6 and leaves bits 5:0 unchanged.
- R4: The setup phase length comes from setup bits 7:6: code 00 gives 4 clocks, 10 gives 3, 01 gives 2 and 11 gives 5. During the setup phase no strobe is asserted.
- R5: Timing bits 7:4 give the active length, with 0 meaning 16. A value of 1 is executed as 2 clocks.
- R6: Timing bits 3:0 give the recovery length, with 0 meaning 16. A value of 1 is executed as 2 clocks when the executed active length is greater than 3, and as 1 clock otherwise.
- R7: When `rev` is 2 or 3, recovery lasts one clock more than in R6. When `rev` is 0 or 1, recovery is exactly as in R6.
- R8: Drives 0 and 1 use their own register pairs. Drives 2 and 3 both use the secondary pair.
- R9: The active phase asserts `rd_strobe` for a read (`start_wr` = 0) or `wr_strobe` for a write (`start_wr` = 1). The two strobes are never high together, and neither is high outside a transfer.
- R10: `start` is accepted only while `busy` is low. `busy` rises in the cycle after acceptance. `done` is high for exactly one cycle after recovery, and `busy` is low in the following cycle.
- R11: The counts are captured when `start` is accepted. Register writes during a transfer do not change that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_setup_only | input | 1 | Limit a setup-register write to bits 7:6 |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data at `cfg_addr` |
| rev | input | 2 | Silicon revision selecting recovery offset |
| start | input | 1 | Transfer request |
| start_drive | input | 2 | Drive index 0..3 for the request |
| start_wr | input | 1 | 1 = write transfer, 0 = read transfer |
| busy | output | 1 | Transfer in progress (including the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| rd_strobe | output | 1 | Read strobe, high during the active phase of a read |
| wr_strobe | output | 1 | Write strobe, high during the active phase of a write |

## Verification
The assertions check the phase structure on every cycle:
- the strobes are exclusive and confined to `busy`;
- no strobe is asserted in the first busy cycle;
- recovery follows the strobe before `done`;
- `done` is a single pulse that ends the transfer;
- an accepted request raises `busy`.

The actual phase lengths depend on the decoding of the encoded bytes, the revision offset, the sharing of the secondary register pair and the snapshot at start. Only the bench's scenarios show these. The bench counts the setup, active and recovery cycles of each transfer and compares them with counts computed from the bytes it wrote.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    localparam int REG_W   = 8;
    localparam int CNT_W   = 5;
    localparam int N_REGS  = 6;
    localparam int ADDR_W  = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOV,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
    } phase_cnt_t;

    function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            2'b00:   n = CNT_W'(4);
            2'b10:   n = CNT_W'(3);
            2'b01:   n = CNT_W'(2);
            default: n = CNT_W'(5);
        endcase
        return n;
    endfunction

    function automatic logic [CNT_W-1:0] nibble_clocks(input logic [3:0] nib);
        return (nib == 4'd0) ? CNT_W'(16) : CNT_W'(nib);
    endfunction

endpackage

// File: rtl/ide_pio_regfile.sv
module ide_pio_regfile
    import ide_pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              setup_only,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [1:0]        drive,
    output logic [REG_W-1:0]  sel_setup,
    output logic [REG_W-1:0]  sel_timing
);
    localparam int N_PAIRS = N_REGS / 2;

    logic [REG_W-1:0] regs [N_REGS];
    logic [1:0]       pair_idx;

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        localparam bit IS_SETUP = (g % 2) == 0;
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && addr == ADDR_W'(g)) begin
                if (IS_SETUP && setup_only)
                    regs[g] <= {wdata[7:6], regs[g][5:0]};
                else
                    regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_REGS; i++)
            if (addr == ADDR_W'(i)) rdata = regs[i];
    end

    // secondary channel drives share the last pair
    assign pair_idx = drive[1] ? 2'(N_PAIRS - 1) : {1'b0, drive[0]};

    always_comb begin
        sel_setup  = '0;
        sel_timing = '0;
        for (int p = 0; p < N_PAIRS; p++) begin
            if (pair_idx == 2'(p)) begin
                sel_setup  = regs[2*p];
                sel_timing = regs[2*p+1];
            end
        end
    end
endmodule

// File: rtl/ide_pio_count_decode.sv
module ide_pio_count_decode
    import ide_pio_pkg::*;
(
    input  logic [REG_W-1:0] setup_byte,
    input  logic [REG_W-1:0] timing_byte,
    input  logic [1:0]       rev,
    output phase_cnt_t       cnt
);
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] rec;

    always_comb begin
        act = nibble_clocks(timing_byte[7:4]);
        if (act == CNT_W'(1)) act = CNT_W'(2);
        rec = nibble_clocks(timing_byte[3:0]);
        if (rec == CNT_W'(1) && act > CNT_W'(3)) rec = CNT_W'(2);
        if (rev > 2'd1) rec = rec + CNT_W'(1);
        cnt.setup  = setup_clocks(setup_byte[7:6]);
        cnt.active = act;
        cnt.recov  = rec;
    end
endmodule

// File: rtl/ide_pio_sequencer.sv
module ide_pio_sequencer
    import ide_pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       start_wr,
    input  phase_cnt_t cnt_in,
    output logic       busy,
    output logic       done,
    output logic       rd_strobe,
    output logic       wr_strobe
);
    phase_e           ph;
    phase_cnt_t       snap;
    logic             is_wr;
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            snap   <= '0;
            is_wr  <= 1'b0;
            remain <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    snap   <= cnt_in;
                    is_wr  <= start_wr;
                    remain <= cnt_in.setup - CNT_W'(1);
                    ph     <= PH_SETUP;
                end
                PH_SETUP: if (remain == '0) begin
                    remain <= snap.active - CNT_W'(1);
                    ph     <= PH_ACTIVE;
                end else remain <= remain - CNT_W'(1);
                PH_ACTIVE: if (remain == '0) begin
                    remain <= snap.recov - CNT_W'(1);
                    ph     <= PH_RECOV;
                end else remain <= remain - CNT_W'(1);
                PH_RECOV: if (remain == '0) ph <= PH_DONE;
                          else remain <= remain - CNT_W'(1);
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (ph != PH_IDLE);
    assign done      = (ph == PH_DONE);
    assign rd_strobe = (ph == PH_ACTIVE) && !is_wr;
    assign wr_strobe = (ph == PH_ACTIVE) && is_wr;
endmodule

// File: rtl/ide_pio_strobe_timer.sv
module ide_pio_strobe_timer
    import ide_pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_setup_only,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic [1:0]        rev,
    input  logic              start,
    input  logic [1:0]        start_drive,
    input  logic              start_wr,
    output logic              busy,
    output logic              done,
    output logic              rd_strobe,
    output logic              wr_strobe
);
    logic [REG_W-1:0] sel_setup;
    logic [REG_W-1:0] sel_timing;
    phase_cnt_t       cnt;

    ide_pio_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .setup_only (cfg_setup_only),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .drive      (start_drive),
        .sel_setup  (sel_setup),
        .sel_timing (sel_timing)
    );

    ide_pio_count_decode u_dec (
        .setup_byte  (sel_setup),
        .timing_byte (sel_timing),
        .rev         (rev),
        .cnt         (cnt)
    );

    ide_pio_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_wr  (start_wr),
        .cnt_in    (cnt),
        .busy      (busy),
        .done      (done),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe)
    );
endmodule

// File: rtl/ide_pio_strobe_timer_chk.sv
module ide_pio_strobe_timer_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic rd_strobe,
    input logic wr_strobe
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_strobe && wr_strobe)); // R9

    AST_STROBE_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe || wr_strobe) |-> (busy && !done)); // R9

    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !(rd_strobe || wr_strobe)); // R4

    AST_RECOV_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_strobe || wr_strobe) |-> (busy && !done)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R10

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done)); // R10
endmodule

bind ide_pio_strobe_timer ide_pio_strobe_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe)
);

// File: tb/ide_pio_strobe_timer_bench.sv
`timescale 1ns/1ps
module ide_pio_strobe_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0, cfg_setup_only = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0, cfg_rdata;
    logic [1:0] rev = 2'd1;
    logic       start = 1'b0, start_wr = 1'b0;
    logic [1:0] start_drive = '0;
    logic       busy, done, rd_strobe, wr_strobe;

    int checks = 0, errors = 0;
    logic [7:0] shadow [6];

    always #4 clk = ~clk;

    ide_pio_strobe_timer u_ide_pio_strobe_timer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_setup_only(cfg_setup_only),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rev(rev), .start(start), .start_drive(start_drive), .start_wr(start_wr),
        .busy(busy), .done(done), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_setup(input logic [1:0] c);
        case (c)
            2'b00: return 4;
            2'b10: return 3;
            2'b01: return 2;
            default: return 5;
        endcase
    endfunction
    function automatic int exp_act(input logic [7:0] t);
        int a = (t[7:4] == 0) ? 16 : int'(t[7:4]);
        return (a == 1) ? 2 : a;
    endfunction
    function automatic int exp_rec(input logic [7:0] t, input logic [1:0] rv);
        int r = (t[3:0] == 0) ? 16 : int'(t[3:0]);
        if (r == 1 && exp_act(t) > 3) r = 2;
        if (rv > 1) r++;
        return r;
    endfunction
    function automatic int pair_of(input logic [1:0] d);
        return d[1] ? 2 : int'(d[0]);
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input bit so);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_setup_only = so;
        @(negedge clk);
        cfg_we = 1'b0; cfg_setup_only = 1'b0;
        if (a < 6) begin
            if (so && a[0] == 1'b0) shadow[a] = {d[7:6], shadow[a][5:0]};
            else shadow[a] = d;
        end
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        cfg_addr = a; #1; d = cfg_rdata;
    endtask

    // runs a transfer and checks phase lengths against shadow registers
    task automatic run_xfer(input logic [1:0] drv, input bit w, input string req,
                            input bit poke_mid, input bit extra_start);
        int s = 0, a = 0, r = 0, dn = 0, bad = 0, n = 0;
        bit seen = 0;
        int p = pair_of(drv);
        int es = exp_setup(shadow[2*p][7:6]);
        int ea = exp_act(shadow[2*p+1]);
        int er = exp_rec(shadow[2*p+1], rev);
        start = 1'b1; start_drive = drv; start_wr = w;
        @(negedge clk);
        start = 1'b0;
        while (busy && n < 100) begin
            if (rd_strobe || wr_strobe) begin
                a++; seen = 1;
                if ((w && !wr_strobe) || (!w && !rd_strobe)) bad++;
            end else if (done) dn++;
            else if (seen) r++;
            else s++;
            if (extra_start && n == 1) begin
                start = 1'b1; start_drive = drv ^ 2'd1; start_wr = !w;
            end
            if (poke_mid && n == 1) begin
                cfg_we = 1'b1; cfg_addr = 3'(2*p+1); cfg_wdata = 8'h21;
                cfg_setup_only = 1'b0;
            end
            @(negedge clk);
            cfg_we = 1'b0; start = 1'b0;
            n++;
        end
        if (poke_mid) shadow[2*p+1] = 8'h21;
        chk(s == es, {req, " setup"}, s, es);
        chk(a == ea, {req, " active"}, a, ea);
        chk(r == er, {req, " recovery"}, r, er);
        chk(dn == 1, {req, " done pulse R10"}, dn, 1);
        chk(bad == 0, {req, " strobe select R9"}, bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h1DE5));
        for (int i = 0; i < 6; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd_reg(3'(i), d);
            chk(d == 8'h00, "R1 reset read", d, 0);
        end
        rev = 2'd1; run_xfer(2'd0, 1'b0, "R1 reset timing", 0, 0);
        rev = 2'd2; run_xfer(2'd0, 1'b1, "R1 R7 reset timing rev2", 0, 0);

        // R2 map and unused addresses
        for (int i = 0; i < 6; i++) wr_reg(3'(i), 8'(8'h11 * (i + 3)), 0);
        wr_reg(3'd6, 8'hAA, 0); wr_reg(3'd7, 8'h55, 0);
        for (int i = 0; i < 8; i++) begin
            rd_reg(3'(i), d);
            chk(d == ((i < 6) ? 8'(8'h11 * (i + 3)) : 8'h00), "R2 readback", d,
                (i < 6) ? 8'h11 * (i + 3) : 0);
        end

        // R3 setup-only write
        wr_reg(3'd0, 8'h2D, 0);
        wr_reg(3'd0, 8'hC0, 1);
        rd_reg(3'd0, d); chk(d == 8'hED, "R3 setup field only", d, 8'hED);
        wr_reg(3'd1, 8'h00, 1);
        rd_reg(3'd1, d); chk(d == 8'h00, "R3 timing full write", d, 0);

        // R4 setup codes, R5/R6/R7 corners
        rev = 2'd1;
        wr_reg(3'd0, 8'h40, 0); wr_reg(3'd1, 8'h11, 0);
        run_xfer(2'd0, 1'b0, "R4 R5 R6 code01 act1 rec1", 0, 0);
        wr_reg(3'd0, 8'h80, 0); wr_reg(3'd1, 8'h31, 0);
        run_xfer(2'd0, 1'b1, "R4 R6 code10 act3 rec1", 0, 0);
        wr_reg(3'd0, 8'hC0, 0); wr_reg(3'd1, 8'h41, 0);
        run_xfer(2'd0, 1'b0, "R4 R6 code11 act4 rec1", 0, 0);
        rev = 2'd3; run_xfer(2'd0, 1'b0, "R7 rev3 act4 rec1", 0, 0);
        rev = 2'd0; run_xfer(2'd0, 1'b1, "R7 rev0", 0, 0);
        wr_reg(3'd1, 8'h0F, 0);
        run_xfer(2'd0, 1'b0, "R5 act0 means 16", 0, 0);

        // R8 drive mapping and shared secondary pair
        rev = 2'd1;
        wr_reg(3'd2, 8'h80, 0); wr_reg(3'd3, 8'h23, 0);
        wr_reg(3'd4, 8'hC0, 0); wr_reg(3'd5, 8'h52, 0);
        run_xfer(2'd1, 1'b0, "R8 drive1", 0, 0);
        run_xfer(2'd0, 1'b0, "R8 drive0 own pair", 0, 0);
        run_xfer(2'd2, 1'b1, "R8 drive2 shared", 0, 0);
        run_xfer(2'd3, 1'b0, "R8 drive3 shared", 0, 0);

        // R11 snapshot, R10 start ignored while busy
        run_xfer(2'd1, 1'b1, "R11 write during transfer", 1, 0);
        rd_reg(3'd3, d); chk(d == 8'h21, "R11 write landed", d, 8'h21);
        run_xfer(2'd3, 1'b0, "R10 start while busy", 0, 1);
        repeat (3) begin
            chk(!busy, "R10 no queued start", busy, 0);
            @(negedge clk);
        end

        // random transfers
        for (int k = 0; k < 40; k++) begin
            logic [1:0] drv = 2'($urandom_range(0, 3));
            int p = pair_of(drv);
            rev = 2'($urandom_range(0, 3));
            wr_reg(3'(2*p), 8'($urandom), bit'($urandom_range(0, 1)));
            wr_reg(3'(2*p+1), 8'($urandom), 0);
            run_xfer(drv, bit'($urandom_range(0, 1)), "R4 R5 R6 R7 R8 random", 0, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule